// File: doc/BRIEF.md
# Dual-Page Memory Flipper with Trigger Stretcher

This block sits between a host and a bus protocol engine that share a memory of two equal pages. Each master supplies a word offset within a page; the block supplies the page bit that becomes the top address bit of each master's full memory address. The host chooses its own page directly. The engine's page is tied to the host's page until automatic flipping is turned on, which is allowed only while the engine runs as a bus monitor.

Once flipping is on, the engine's page moves independently. Each time the engine reports that its monitor buffer is full, the engine page toggles, and in the same clock a one-cycle half-full interrupt is raised to the host. Capture then continues in the fresh page while the host drains the other one.

Message interrupts, from the engine or from the half-full event, are turned into an active-high trigger pulse of a fixed number of clocks. A new interrupt during a pulse restarts its length. In monitor mode the trigger stays gated shut until a chosen monitor block completes. That block is block 0 when flipping is on and block 1 when it is off.

The page controller has two states. PG_TRACK follows the host page. PG_PINGPONG keeps an independent engine page. A set request in monitor mode without a clear request takes PG_TRACK to PG_PINGPONG. Any clear request takes PG_PINGPONG to PG_TRACK.

The trigger gate has two states. GT_SHUT withholds triggers. GT_OPEN passes them. The right block completion in monitor mode takes GT_SHUT to GT_OPEN. Leaving monitor mode takes GT_OPEN back to GT_SHUT.

The stretcher has two states. A fired interrupt takes TG_IDLE to TG_PULSE. The count running out takes TG_PULSE back to TG_IDLE. Another interrupt reloads the count while in TG_PULSE.

Top module: `pageflip_trig`

## Requirements
- R1: While rst_n is low, eng_page, flip_on, half_irq and trig are all 0.
- R2: While flip_on is 0 at a clock edge, eng_page after that edge equals the host_page sampled at that edge. The engine page therefore follows the host page one cycle late, including the first cycle after flipping is switched off.
- R3: flip_on becomes 1 after an edge where flip_set_req is 1, flip_clr_req is 0 and mon_mode is 1. A set request with mon_mode at 0 is ignored. A clear request clears flip_on, and wins when it arrives together with a set request.
- R4: While flip_on is 1, host_page has no effect on eng_page. An edge with buf_full at 1 toggles eng_page, and half_irq is 1 for exactly the cycle after that edge. half_irq is never 1 after an edge where flip_on was 0.
- R5: When flipping is switched on, eng_page keeps its current value, which is the host page it was tracking.
- R6: When a message interrupt (eng_irq, or half_irq) is seen at an edge while the gate is open, trig is 1 for exactly TRIG_CYC cycles starting after that edge. A further interrupt during the pulse restarts the full count.
- R7: When mon_mode is 0, the gate is always open. When mon_mode is 1, interrupts produce no trigger until a blk_done with blk_idx equal to 0 (flip_on is 1) or 1 (flip_on is 0) is seen. The gate opens from that same edge and stays open until mon_mode returns to 0.
- R8: host_mem_addr is {host_page, host_ofs} and eng_mem_addr is {eng_page, eng_ofs}, with the page bit as the most significant bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_page | input | 1 | Page selected by the host |
| host_ofs | input | OFS_W | Host word offset within a page |
| eng_ofs | input | OFS_W | Engine word offset within a page |
| flip_set_req | input | 1 | Request to switch automatic flipping on |
| flip_clr_req | input | 1 | Request to switch automatic flipping off |
| mon_mode | input | 1 | Engine is operating as a bus monitor |
| blk_done | input | 1 | One-cycle pulse: a monitor block completed |
| blk_idx | input | BLK_W | Index of the completed monitor block |
| buf_full | input | 1 | One-cycle pulse: all monitor blocks written |
| eng_irq | input | 1 | One-cycle message interrupt from the engine |
| eng_page | output | 1 | Page bit used by the engine |
| flip_on | output | 1 | Automatic flipping is active |
| half_irq | output | 1 | One-cycle half-full interrupt to the host |
| trig | output | 1 | Stretched trigger pulse |
| host_mem_addr | output | OFS_W+1 | Full host memory address |
| eng_mem_addr | output | OFS_W+1 | Full engine memory address |

## Verification
A page controller stuck in the wrong state shows within one cycle. eng_page either fails to follow a host_page change, or follows one it should ignore. A wrong page register shows on eng_mem_addr at the first buf_full. A gate that opens early or late shows as a trig rising, or failing to rise, in the cycle after an interrupt. A stretcher count that is off by one shows on the cycle trig falls, TRIG_CYC cycles after its last interrupt. The bench compares all outputs against its own model every cycle, so each such divergence is caught on the cycle it first reaches a port.

// File: rtl/pf_pkg.sv
package pf_pkg;
    typedef enum logic {PG_TRACK, PG_PINGPONG} pg_state_e;
    typedef enum logic {GT_SHUT, GT_OPEN}      gt_state_e;
    typedef enum logic {TG_IDLE, TG_PULSE}     tg_state_e;
endpackage

// File: rtl/pf_page_ctl.sv
module pf_page_ctl
    import pf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic host_page,
    input  logic flip_set_req,
    input  logic flip_clr_req,
    input  logic mon_mode,
    input  logic buf_full,
    output logic eng_page,
    output logic flip_on,
    output logic half_irq
);
    pg_state_e state_q, state_d;
    logic      page_q;
    logic      hirq_q;

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PG_TRACK:    if (flip_set_req && !flip_clr_req && mon_mode) state_d = PG_PINGPONG;
            PG_PINGPONG: if (flip_clr_req) state_d = PG_TRACK;
            default:     state_d = PG_TRACK;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PG_TRACK;
        else        state_q <= state_d;
    end

    // Output registers: page bit and half-full interrupt issued together
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q <= 1'b0;
            hirq_q <= 1'b0;
        end else begin
            unique case (state_q)
                PG_TRACK: begin
                    page_q <= host_page;
                    hirq_q <= 1'b0;
                end
                PG_PINGPONG: begin
                    if (buf_full) page_q <= ~page_q;
                    hirq_q <= buf_full;
                end
                default: begin
                    page_q <= host_page;
                    hirq_q <= 1'b0;
                end
            endcase
        end
    end

    assign eng_page = page_q;
    assign flip_on  = (state_q == PG_PINGPONG);
    assign half_irq = hirq_q;

    p_track_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !flip_on |=> eng_page == $past(host_page));
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        flip_on && !buf_full |=> $stable(eng_page));
    p_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
        flip_on && buf_full |=> (eng_page != $past(eng_page)) && half_irq);
    p_no_hirq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !flip_on |=> !half_irq);
    p_set_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !flip_on && !mon_mode |=> !flip_on);
    p_clr_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        flip_clr_req |=> !flip_on);
    p_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flip_on) |-> $stable(eng_page) || ($past(host_page) == eng_page));
endmodule

// File: rtl/pf_trig_gate.sv
module pf_trig_gate
    import pf_pkg::*;
#(
    parameter int BLK_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mon_mode,
    input  logic             flip_on,
    input  logic             blk_done,
    input  logic [BLK_W-1:0] blk_idx,
    output logic             gate_open
);
    localparam logic [BLK_W-1:0] IDX_FLIP   = '0;
    localparam logic [BLK_W-1:0] IDX_NOFLIP = BLK_W'(1);

    gt_state_e state_q, state_d;
    logic      hit;

    assign hit = blk_done && (blk_idx == (flip_on ? IDX_FLIP : IDX_NOFLIP));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GT_SHUT: if (mon_mode && hit) state_d = GT_OPEN;
            GT_OPEN: if (!mon_mode) state_d = GT_SHUT;
            default: state_d = GT_SHUT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GT_SHUT;
        else        state_q <= state_d;
    end

    always_comb begin
        gate_open = !mon_mode || (state_q == GT_OPEN) || hit;
    end

    p_leave_shut_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !mon_mode |=> state_q == GT_SHUT);
    p_stay_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == GT_OPEN && mon_mode |=> gate_open);
endmodule

// File: rtl/pf_trig_stretch.sv
module pf_trig_stretch
    import pf_pkg::*;
#(
    parameter int TRIG_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic trig
);
    localparam int CNT_W = $clog2(TRIG_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(TRIG_CYC);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    tg_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            TG_IDLE: begin
                if (fire) begin
                    state_d = TG_PULSE;
                    cnt_d   = CNT_LOAD;
                end
            end
            TG_PULSE: begin
                if (fire) begin
                    cnt_d = CNT_LOAD;
                end else if (cnt_q == CNT_ONE) begin
                    state_d = TG_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q - CNT_ONE;
                end
            end
            default: begin
                state_d = TG_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TG_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        trig = (state_q == TG_PULSE);
    end

    initial begin
        p_cyc_param_r6: assert (TRIG_CYC >= 1);
    end

    p_fire_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> trig);
    p_rise_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trig) |-> $past(fire));
    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_LOAD);
endmodule

// File: rtl/pageflip_trig.sv
module pageflip_trig #(
    parameter int OFS_W    = 16,
    parameter int BLK_W    = 3,
    parameter int TRIG_CYC = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_page,
    input  logic [OFS_W-1:0] host_ofs,
    input  logic [OFS_W-1:0] eng_ofs,
    input  logic             flip_set_req,
    input  logic             flip_clr_req,
    input  logic             mon_mode,
    input  logic             blk_done,
    input  logic [BLK_W-1:0] blk_idx,
    input  logic             buf_full,
    input  logic             eng_irq,
    output logic             eng_page,
    output logic             flip_on,
    output logic             half_irq,
    output logic             trig,
    output logic [OFS_W:0]   host_mem_addr,
    output logic [OFS_W:0]   eng_mem_addr
);
    logic gate_open;
    logic fire;

    pf_page_ctl u_page (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_page    (host_page),
        .flip_set_req (flip_set_req),
        .flip_clr_req (flip_clr_req),
        .mon_mode     (mon_mode),
        .buf_full     (buf_full),
        .eng_page     (eng_page),
        .flip_on      (flip_on),
        .half_irq     (half_irq)
    );

    pf_trig_gate #(.BLK_W(BLK_W)) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .mon_mode  (mon_mode),
        .flip_on   (flip_on),
        .blk_done  (blk_done),
        .blk_idx   (blk_idx),
        .gate_open (gate_open)
    );

    assign fire = gate_open && (eng_irq || half_irq);

    pf_trig_stretch #(.TRIG_CYC(TRIG_CYC)) u_stretch (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (fire),
        .trig  (trig)
    );

    assign host_mem_addr = {host_page, host_ofs};
    assign eng_mem_addr  = {eng_page, eng_ofs};

    p_hirq_trig_r6: assert property (@(posedge clk) disable iff (!rst_n)
        half_irq && !mon_mode |=> trig);
    p_shut_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !trig && !gate_open |=> !trig);
endmodule

// File: tb/pageflip_trig_bench.sv
module pageflip_trig_bench;
    localparam int OFS_W = 16;
    localparam int BLK_W = 3;
    localparam int TCYC  = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_page = 1'b0;
    logic [OFS_W-1:0] host_ofs = '0;
    logic [OFS_W-1:0] eng_ofs = '0;
    logic flip_set_req = 1'b0;
    logic flip_clr_req = 1'b0;
    logic mon_mode = 1'b0;
    logic blk_done = 1'b0;
    logic [BLK_W-1:0] blk_idx = '0;
    logic buf_full = 1'b0;
    logic eng_irq = 1'b0;
    logic eng_page, flip_on, half_irq, trig;
    logic [OFS_W:0] host_mem_addr, eng_mem_addr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference model state
    int m_page = 0, m_flip = 0, m_hirq = 0, m_open = 0, m_cnt = 0;

    pageflip_trig #(.OFS_W(OFS_W), .BLK_W(BLK_W), .TRIG_CYC(TCYC)) u_pageflip_trig (
        .clk(clk), .rst_n(rst_n), .host_page(host_page), .host_ofs(host_ofs),
        .eng_ofs(eng_ofs), .flip_set_req(flip_set_req), .flip_clr_req(flip_clr_req),
        .mon_mode(mon_mode), .blk_done(blk_done), .blk_idx(blk_idx),
        .buf_full(buf_full), .eng_irq(eng_irq), .eng_page(eng_page),
        .flip_on(flip_on), .half_irq(half_irq), .trig(trig),
        .host_mem_addr(host_mem_addr), .eng_mem_addr(eng_mem_addr)
    );

    always #10 clk = ~clk;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_page = 0; m_flip = 0; m_hirq = 0; m_open = 0; m_cnt = 0;
        end else begin
            int n_flip, n_page, n_open, gate, hit, target;
            n_flip = m_flip;
            if (flip_clr_req) n_flip = 0;
            else if (flip_set_req && mon_mode) n_flip = 1;
            if (m_flip == 0) n_page = host_page;
            else n_page = buf_full ? 1 - m_page : m_page;
            target = (m_flip != 0) ? 0 : 1;
            hit  = (blk_done && int'(blk_idx) == target) ? 1 : 0;
            gate = (!mon_mode || m_open != 0 || hit != 0) ? 1 : 0;
            n_open = (mon_mode && (m_open != 0 || hit != 0)) ? 1 : 0;
            if (gate != 0 && (eng_irq || m_hirq != 0)) m_cnt = TCYC;
            else if (m_cnt > 0) m_cnt = m_cnt - 1;
            m_hirq = (m_flip != 0 && buf_full) ? 1 : 0;
            m_flip = n_flip;
            m_page = n_page;
            m_open = n_open;
        end
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            if (!rst_n) begin
                chk("R1", "eng_page", int'(eng_page), 0);
                chk("R1", "flip_on", int'(flip_on), 0);
                chk("R1", "half_irq", int'(half_irq), 0);
                chk("R1", "trig", int'(trig), 0);
            end else begin
                chk(m_flip != 0 ? "R4" : "R2", "eng_page", int'(eng_page), m_page);
                chk("R3", "flip_on", int'(flip_on), m_flip);
                chk("R4", "half_irq", int'(half_irq), m_hirq);
                chk(mon_mode ? "R7" : "R6", "trig", int'(trig), (m_cnt > 0) ? 1 : 0);
                chk("R8", "host_mem_addr", int'(host_mem_addr), int'(host_page) * (1 << OFS_W) + int'(host_ofs));
                chk("R8", "eng_mem_addr", int'(eng_mem_addr), m_page * (1 << OFS_W) + int'(eng_ofs));
            end
        end
    end

    task automatic cyc(input bit bf, input bit bd, input int idx, input bit irq,
                       input bit set, input bit clr);
        buf_full = bf; blk_done = bd; blk_idx = BLK_W'(idx); eng_irq = irq;
        flip_set_req = set; flip_clr_req = clr;
        host_ofs = OFS_W'($urandom); eng_ofs = OFS_W'($urandom);
        @(negedge clk); #2;
        buf_full = 0; blk_done = 0; eng_irq = 0; flip_set_req = 0; flip_clr_req = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        #2 rst_n = 1'b1;
        // R2: tracking outside monitor mode; R3: set ignored without monitor mode
        host_page = 1; idle(2);
        cyc(0, 0, 0, 0, 1, 0);
        host_page = 0; idle(2);
        // R6: trigger pulse, ungated; restart during pulse
        cyc(0, 0, 0, 1, 0, 0); idle(5);
        cyc(0, 0, 0, 1, 0, 0); idle(TCYC + 3);
        // R7: monitor mode without flipping waits for block 1
        mon_mode = 1; idle(1);
        cyc(0, 0, 0, 1, 0, 0); idle(2);
        cyc(0, 1, 0, 0, 0, 0);
        cyc(0, 0, 0, 1, 0, 0); idle(2);
        cyc(0, 1, 1, 1, 0, 0); idle(TCYC + 2);
        cyc(0, 0, 0, 1, 0, 0); idle(TCYC + 2);
        // R4: buf_full without flipping raises nothing
        cyc(1, 0, 0, 0, 0, 0); idle(2);
        // R3/R5: set and clear together clears; then set alone on host page 1
        host_page = 1; idle(1);
        cyc(0, 0, 0, 0, 1, 1); idle(1);
        cyc(0, 0, 0, 0, 1, 0); idle(1);
        // R4: host page ignored, buf_full flips and interrupts
        host_page = 0; idle(2);
        cyc(1, 0, 0, 0, 0, 0); idle(3);
        host_page = 1; idle(2);
        // leave and re-enter monitor mode: gate needs block 0 now
        mon_mode = 0; idle(1);
        mon_mode = 1; idle(1);
        cyc(1, 0, 0, 0, 0, 0); idle(3);
        cyc(0, 1, 1, 1, 0, 0); idle(3);
        cyc(0, 1, 0, 0, 0, 0);
        cyc(1, 0, 0, 0, 0, 0); idle(TCYC + 2);
        // R2: clear flipping, page resynchronises
        cyc(0, 0, 0, 0, 0, 1); idle(3);
        // Random stretch
        for (int i = 0; i < 4000; i++) begin
            if (($urandom % 40) == 0) mon_mode = ~mon_mode;
            if (($urandom % 7) == 0) host_page = ~host_page;
            cyc(($urandom % 12) == 0, ($urandom % 6) == 0, int'($urandom % 4),
                ($urandom % 20) == 0, ($urandom % 9) == 0, ($urandom % 23) == 0);
        end
        idle(TCYC + 2);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule